// File: doc/BRIEF.md
# Two-Wire Single-Target Register Master

This block is a bus master for a push/pull two-wire serial link that has exactly one target device on it. Software sets up a single-byte register access through a small memory-mapped register set: the target's register address, a data byte, a length/direction word and an interrupt enable word. It then writes the start bit. The serial engine produces a start condition and a compact frame, then a stop condition. The frame has no device address and no acknowledge slots, and an odd parity bit follows every byte.

A read is a single access. The master sends the direction bit, the register address and its parity. It then releases the data line and clocks in the target's data byte and parity in the same frame. A good byte lands in the data register. A bad parity raises the error flag. Three write-one-to-clear status flags (complete, error, load-while-busy) are gated by per-flag enables and a global enable into one interrupt output. The serial clock is the system clock divided down to a parameter rate.

Top module: `tw_regmaster`

## Requirements
- R1: After reset the register map reads as follows, with offsets given by `csr_addr`: control (0) = 0x00, interrupt enable (1) = 0x00, status (2) = 0x00, register address (3) = 0x00, data (4) = 0x00, length/direction (5) = 0x01. `scl` is 1, `sda_oe` is 1, `sda_out` is 1 and `irq` is 0.
- R2: A transfer starts with a start condition: data falls while the clock is high. Exactly 19 data clocks follow. They carry the direction bit (1 = read, taken from bit 7 of the length/direction register), 8 register address bits MSB first, a parity bit, 8 data bits MSB first and a parity bit. The frame then ends with one more clock pulse during which data rises while the clock is high (stop). There is no device address and no acknowledge slot.
- R3: Each parity bit is odd: the byte and its parity bit together hold an odd number of ones. A bit is valid while the clock is high, and data does not change during that high time.
- R4: On a read, the 8 bits and parity returned by the target in clocks 11 to 19 are sampled at the end of each high phase. When the parity is good, the byte is written to the data register.
- R5: Writing control bit 0 (start) while idle launches a transfer. Bit 0 reads back as 1 from that write until the stop completes and as 0 after it.
- R6: Status bit 0 (complete) is set at the end of every transfer. `irq` is 1 exactly when control bit 1 (global enable) is set and some status bit is set whose interrupt enable bit (same position) is also set.
- R7: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R8: A write to control, register address, data or length/direction while a transfer runs has no effect and sets status bit 2 (load-while-busy).
- R9: A read whose received parity is wrong sets status bit 1 (error) together with the complete flag and leaves the data register unchanged.
- R10: `sda_oe` is 0 during the data and parity clocks of a read and 1 at all other times.
- R11: Every half period of `scl` lasts CLK_HZ/(2*SCL_HZ) system clocks. SCL_HZ may not exceed 6 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register offset |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data (combinational on csr_addr) |
| irq | output | 1 | Interrupt request |
| scl | output | 1 | Serial clock, push/pull |
| sda_out | output | 1 | Serial data driven by the master |
| sda_oe | output | 1 | Data line drive enable |
| sda_in | input | 1 | Serial data from the target |

## Verification
A register write takes effect on the clock edge that samples the strobe. Reads are combinational, so the bench reads one cycle after each write. The start condition appears on the line in the cycle after the start write. Every later line event follows at a multiple of the half period, and status, data and the start bit all change on the single edge that ends the stop half period. The bench therefore polls the start bit until it drops, then checks flags, data and `irq`, waiting a few more cycles so that the line monitor has already scored the frame. The line monitor samples on the falling system clock edge. It times the first clock high phase, drives read response bits on clock falls and compares each captured frame against the item that the driver task queued.

// File: rtl/tw_regmaster_pkg.sv
package tw_regmaster_pkg;

    localparam int CSR_AW = 3;
    localparam int CSR_DW = 8;

    localparam logic [CSR_AW-1:0] OFS_CTRL  = 3'd0;
    localparam logic [CSR_AW-1:0] OFS_IEN   = 3'd1;
    localparam logic [CSR_AW-1:0] OFS_STAT  = 3'd2;
    localparam logic [CSR_AW-1:0] OFS_RADDR = 3'd3;
    localparam logic [CSR_AW-1:0] OFS_DATA  = 3'd4;
    localparam logic [CSR_AW-1:0] OFS_LEN   = 3'd5;

    localparam int CTRL_GO  = 0;
    localparam int CTRL_GIE = 1;
    localparam int LEN_RD   = 7;
    localparam int LEN_W    = 4;

    // frame: dir bit, address byte, parity, data byte, parity
    localparam int FRAME_BITS = 19;
    localparam int RX_FIRST   = 10;
    localparam int MAX_SCL_HZ = 6_000_000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_LOW,
        ST_HIGH,
        ST_STP_LOW,
        ST_STP_HIGH
    } line_state_e;

    typedef struct packed {
        logic lwb;
        logic err;
        logic done;
    } flags_t;

    typedef struct packed {
        logic       is_read;
        logic [7:0] addr;
        logic [7:0] wdata;
    } xfer_req_t;

    function automatic logic odd_parity(input logic [7:0] b);
        return ~(^b);
    endfunction

    function automatic int half_period(input int clk_hz, input int scl_hz);
        int h;
        h = clk_hz / (2 * scl_hz);
        return (h < 1) ? 1 : h;
    endfunction

endpackage

// File: rtl/tw_tick_gen.sv
module tw_tick_gen #(
    parameter int HALF_CYCLES = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = $clog2(HALF_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    generate
        if (HALF_CYCLES > 1) begin : g_gap
            p_tick_gap_r11: assert property (@(posedge clk) disable iff (rst || clr)
                tick |=> !tick)
                else $error("tick pulses too close");
        end
    endgenerate

endmodule

// File: rtl/tw_line_engine.sv
module tw_line_engine
    import tw_regmaster_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       launch,
    input  xfer_req_t  req,
    input  logic       tick,
    input  logic       sda_in,
    output logic       busy,
    output logic       scl,
    output logic       sda_out,
    output logic       sda_oe,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       par_err
);
    localparam int IDXW = $clog2(FRAME_BITS);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(FRAME_BITS - 1);
    localparam logic [IDXW-1:0] RX_IDX   = IDXW'(RX_FIRST);

    line_state_e           state;
    logic [FRAME_BITS-1:0] tx;
    logic [IDXW-1:0]       idx;
    logic [8:0]            rx;
    logic                  rd_q;
    logic                  rx_phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            tx    <= '0;
            idx   <= '0;
            rx    <= '0;
            rd_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (launch) begin
                    state <= ST_START;
                    tx    <= {req.is_read, req.addr, odd_parity(req.addr),
                              req.wdata, odd_parity(req.wdata)};
                    idx   <= '0;
                    rx    <= '0;
                    rd_q  <= req.is_read;
                end
                ST_START: if (tick) state <= ST_LOW;
                ST_LOW:   if (tick) state <= ST_HIGH;
                ST_HIGH:  if (tick) begin
                    if (rd_q && idx >= RX_IDX) rx <= {rx[7:0], sda_in};
                    if (idx == LAST_IDX) begin
                        state <= ST_STP_LOW;
                    end else begin
                        idx   <= idx + 1'b1;
                        tx    <= tx << 1;
                        state <= ST_LOW;
                    end
                end
                ST_STP_LOW:  if (tick) state <= ST_STP_HIGH;
                ST_STP_HIGH: if (tick) state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    assign rx_phase = rd_q && (idx >= RX_IDX) && (state == ST_LOW || state == ST_HIGH);

    always_comb begin
        scl     = 1'b1;
        sda_out = 1'b1;
        unique case (state)
            ST_IDLE:     begin scl = 1'b1; sda_out = 1'b1; end
            ST_START:    begin scl = 1'b1; sda_out = 1'b0; end
            ST_LOW:      begin scl = 1'b0; sda_out = rx_phase ? 1'b1 : tx[FRAME_BITS-1]; end
            ST_HIGH:     begin scl = 1'b1; sda_out = rx_phase ? 1'b1 : tx[FRAME_BITS-1]; end
            ST_STP_LOW:  begin scl = 1'b0; sda_out = 1'b0; end
            ST_STP_HIGH: begin scl = 1'b1; sda_out = 1'b0; end
            default:     begin scl = 1'b1; sda_out = 1'b1; end
        endcase
    end

    assign sda_oe  = !rx_phase;
    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_STP_HIGH) && tick;
    assign rx_byte = rx[8:1];
    assign par_err = rd_q && !(^rx);

    p_launch_start_r2: assert property (@(posedge clk) disable iff (rst)
        launch |=> (scl && !sda_out && sda_oe))
        else $error("no start condition after launch");

    p_sda_steady_high_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIGH && $past(state) == ST_HIGH) |-> ($stable(sda_out) && $stable(sda_oe)))
        else $error("data moved while clock high");

endmodule

// File: rtl/tw_csr.sv
module tw_csr
    import tw_regmaster_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CSR_AW-1:0] addr,
    input  logic [CSR_DW-1:0] wdata,
    output logic [CSR_DW-1:0] rdata,
    input  logic              engine_busy,
    input  logic              eng_done,
    input  logic              par_err,
    input  logic [7:0]        rx_byte,
    output logic              launch,
    output xfer_req_t         req,
    output logic              irq
);
    logic             go_q, gie_q, rd_q;
    flags_t           ien_q, stat_q, stat_set, stat_clr;
    logic [7:0]       raddr_q, data_q;
    logic [LEN_W-1:0] len_q;
    logic             cfg_hit, blocked, open_wr;

    assign cfg_hit = wr_en && (addr == OFS_CTRL || addr == OFS_RADDR ||
                               addr == OFS_DATA || addr == OFS_LEN);
    assign blocked = cfg_hit && go_q;
    assign open_wr = wr_en && !go_q;
    assign launch  = open_wr && (addr == OFS_CTRL) && wdata[CTRL_GO];

    always_comb begin
        stat_set.done = eng_done;
        stat_set.err  = eng_done && rd_q && par_err;
        stat_set.lwb  = blocked;
        stat_clr      = (wr_en && addr == OFS_STAT) ? flags_t'(wdata[2:0]) : flags_t'(3'b000);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q    <= 1'b0;
            gie_q   <= 1'b0;
            rd_q    <= 1'b0;
            ien_q   <= '0;
            stat_q  <= '0;
            raddr_q <= '0;
            data_q  <= '0;
            len_q   <= LEN_W'(1);
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
            if (wr_en && addr == OFS_IEN) ien_q <= flags_t'(wdata[2:0]);
            if (eng_done) begin
                go_q <= 1'b0;
                if (rd_q && !par_err) data_q <= rx_byte;
            end
            if (open_wr) begin
                unique case (addr)
                    OFS_CTRL: begin
                        go_q  <= wdata[CTRL_GO];
                        gie_q <= wdata[CTRL_GIE];
                    end
                    OFS_RADDR: raddr_q <= wdata;
                    OFS_DATA:  data_q  <= wdata;
                    OFS_LEN: begin
                        rd_q  <= wdata[LEN_RD];
                        len_q <= wdata[LEN_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (addr)
            OFS_CTRL:  rdata = {6'b0, gie_q, go_q};
            OFS_IEN:   rdata = {5'b0, ien_q};
            OFS_STAT:  rdata = {5'b0, stat_q};
            OFS_RADDR: rdata = raddr_q;
            OFS_DATA:  rdata = data_q;
            OFS_LEN:   rdata = {rd_q, {(7-LEN_W){1'b0}}, len_q};
            default:   rdata = '0;
        endcase
    end

    assign req.is_read = rd_q;
    assign req.addr    = raddr_q;
    assign req.wdata   = data_q;
    assign irq         = gie_q && |(stat_q & ien_q);

    p_busy_covers_engine_r5: assert property (@(posedge clk) disable iff (rst)
        engine_busy |-> go_q)
        else $error("engine running with start bit low");

    p_done_flag_r6: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> stat_q.done)
        else $error("complete flag not set");

    p_blocked_raddr_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && go_q && addr == OFS_RADDR) |=> ($stable(raddr_q) && stat_q.lwb))
        else $error("write during transfer took effect");

    p_w1c_only_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_q.done) |-> $past(wr_en && addr == OFS_STAT && wdata[0]))
        else $error("complete flag cleared without a write of one");

endmodule

// File: rtl/tw_regmaster.sv
module tw_regmaster
    import tw_regmaster_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int SCL_HZ = 100_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       csr_wr,
    input  logic [2:0] csr_addr,
    input  logic [7:0] csr_wdata,
    output logic [7:0] csr_rdata,
    output logic       irq,
    output logic       scl,
    output logic       sda_out,
    output logic       sda_oe,
    input  logic       sda_in
);
    localparam int HALF = half_period(CLK_HZ, SCL_HZ);

    logic      launch, tick, busy, done, par_err;
    logic [7:0] rx_byte;
    xfer_req_t req;

    initial begin
        p_scl_limit_r11: assert (SCL_HZ > 0 && SCL_HZ <= MAX_SCL_HZ)
            else $error("serial clock rate out of range");
    end

    tw_csr u_csr (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (csr_wr),
        .addr        (csr_addr),
        .wdata       (csr_wdata),
        .rdata       (csr_rdata),
        .engine_busy (busy),
        .eng_done    (done),
        .par_err     (par_err),
        .rx_byte     (rx_byte),
        .launch      (launch),
        .req         (req),
        .irq         (irq)
    );

    tw_tick_gen #(.HALF_CYCLES(HALF)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (!busy),
        .tick (tick)
    );

    tw_line_engine u_engine (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .req     (req),
        .tick    (tick),
        .sda_in  (sda_in),
        .busy    (busy),
        .scl     (scl),
        .sda_out (sda_out),
        .sda_oe  (sda_oe),
        .done    (done),
        .rx_byte (rx_byte),
        .par_err (par_err)
    );

endmodule

// File: tb/tw_regmaster_bench.sv
module tw_regmaster_bench;
    localparam int CLK_HZ = 50_000_000;
    localparam int SCL_HZ = 1_000_000;
    localparam int HALF   = CLK_HZ / (2 * SCL_HZ);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       csr_wr = 1'b0;
    logic [2:0] csr_addr = 3'd0;
    logic [7:0] csr_wdata = 8'd0;
    logic [7:0] csr_rdata;
    logic       irq, scl, sda_out, sda_oe;
    logic       sda_in = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        bit       rd;
        bit [7:0] addr;
        bit [7:0] wdata;
        bit [7:0] resp;
        bit       bad_par;
    } item_t;

    item_t exp_q[$];

    always #10 clk = ~clk;

    tw_regmaster #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) u_tw_regmaster (
        .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
        .scl(scl), .sda_out(sda_out), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    function automatic bit oddp(input bit [7:0] b);
        return ~(^b);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic csr_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 5000; i++) begin
            csr_read(3'd0, v);
            if (!v[0]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    // driver: queue expectation, program registers, launch
    task automatic launch_xfer(input bit rd, input bit [7:0] a, input bit [7:0] wd,
                               input bit [7:0] resp, input bit bad, input logic [7:0] ctrl);
        item_t it;
        it.rd = rd; it.addr = a; it.wdata = wd; it.resp = resp; it.bad_par = bad;
        exp_q.push_back(it);
        csr_write(3'd3, a);
        if (!rd) csr_write(3'd4, wd);
        csr_write(3'd5, rd ? 8'h81 : 8'h01);
        csr_write(3'd0, ctrl);
    endtask

    // monitor: target model and frame scoreboard
    logic        prev_scl = 1'b1, prev_line = 1'b1, line;
    bit          in_frame = 0;
    int          nbits = 0, rises = 0, hi_cnt = 0;
    logic [18:0] cap;
    item_t       cur;
    logic [8:0]  resp9;

    always @(negedge clk) begin
        line = sda_oe ? sda_out : sda_in;
        if (!rst) begin
            if (!in_frame && prev_scl && scl && prev_line && !line) begin
                in_frame = 1; nbits = 0; rises = 0; hi_cnt = 0; cap = '0;
                if (exp_q.size() == 0) check("R2", "unexpected frame", 1, 0);
                else cur = exp_q[0];
                resp9 = {cur.resp, cur.bad_par ? ~oddp(cur.resp) : oddp(cur.resp)};
            end else if (in_frame) begin
                if (!prev_scl && scl) begin
                    rises++;
                    hi_cnt = 1;
                    if (nbits < 19) begin
                        cap = {cap[17:0], line};
                        nbits++;
                        if (nbits == 1)  check("R10", "oe during dir bit", sda_oe, 1);
                        if (nbits == 11 && cur.rd) check("R10", "oe released in read data", sda_oe, 0);
                        if (nbits == 11 && !cur.rd) check("R10", "oe in write data", sda_oe, 1);
                    end
                end else if (prev_scl && scl) begin
                    hi_cnt++;
                end
                if (prev_scl && !scl) begin
                    if (rises == 1) check("R11", "scl high length", hi_cnt, HALF);
                    if (cur.rd && nbits >= 10 && nbits < 19) sda_in = resp9[18 - nbits];
                    else sda_in = 1'b1;
                end
                if (prev_scl && scl && !prev_line && line) begin
                    in_frame = 0;
                    sda_in = 1'b1;
                    check("R2", "clock pulses", rises, 20);
                    check("R2", "dir bit", cap[18], cur.rd);
                    check("R2", "address", cap[17:10], cur.addr);
                    check("R3", "address parity", cap[9], oddp(cur.addr));
                    if (!cur.rd) begin
                        check("R2", "write data", cap[8:1], cur.wdata);
                        check("R3", "data parity", cap[0], oddp(cur.wdata));
                    end
                    void'(exp_q.pop_front());
                end
            end
        end
        prev_scl = scl;
        prev_line = line;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        csr_read(3'd0, v); check("R1", "ctrl", v, 8'h00);
        csr_read(3'd1, v); check("R1", "ien", v, 8'h00);
        csr_read(3'd2, v); check("R1", "status", v, 8'h00);
        csr_read(3'd3, v); check("R1", "raddr", v, 8'h00);
        csr_read(3'd4, v); check("R1", "data", v, 8'h00);
        csr_read(3'd5, v); check("R1", "len", v, 8'h01);
        check("R1", "scl", scl, 1); check("R1", "sda_out", sda_out, 1);
        check("R1", "sda_oe", sda_oe, 1); check("R1", "irq", irq, 0);

        // write, gie off, with blocked writes during it
        csr_write(3'd1, 8'h01);
        launch_xfer(0, 8'h5A, 8'hC3, 8'h00, 0, 8'h01);
        csr_read(3'd0, v); check("R5", "start bit while busy", v[0], 1);
        csr_write(3'd3, 8'hFF);
        csr_write(3'd0, 8'h02);
        wait_idle();
        csr_read(3'd0, v); check("R5", "ctrl after stop", v, 8'h00);
        check("R8", "gie unchanged by busy write", v[1], 0);
        csr_read(3'd3, v); check("R8", "raddr kept", v, 8'h5A);
        csr_read(3'd2, v); check("R6", "status done+lwb", v, 8'h05);
        check("R6", "irq gated by gie", irq, 0);

        // R7 write-one-to-clear
        csr_write(3'd2, 8'h04);
        csr_read(3'd2, v); check("R7", "clear lwb only", v, 8'h01);
        csr_write(3'd2, 8'h00);
        csr_read(3'd2, v); check("R7", "zero write keeps", v, 8'h01);
        csr_write(3'd2, 8'h01);
        csr_read(3'd2, v); check("R7", "clear done", v, 8'h00);

        // R4 good read with interrupts on
        csr_write(3'd0, 8'h02);
        csr_read(3'd0, v); check("R5", "gie write does not launch", v, 8'h02);
        launch_xfer(1, 8'h81, 8'h00, 8'h3C, 0, 8'h03);
        wait_idle();
        csr_read(3'd4, v); check("R4", "read data", v, 8'h3C);
        csr_read(3'd2, v); check("R6", "status after read", v, 8'h01);
        check("R6", "irq raised", irq, 1);
        csr_write(3'd1, 8'h00);
        check("R6", "irq masked by enable", irq, 0);
        csr_write(3'd1, 8'h01);
        csr_write(3'd2, 8'h01);
        check("R6", "irq after clear", irq, 0);

        // R9 read with bad parity
        launch_xfer(1, 8'h17, 8'h00, 8'hA5, 1, 8'h03);
        wait_idle();
        csr_read(3'd4, v); check("R9", "data unchanged", v, 8'h3C);
        csr_read(3'd2, v); check("R9", "status err+done", v, 8'h03);
        csr_write(3'd2, 8'h03);

        // boundary data bytes, R3 parity of all-ones / all-zeros
        launch_xfer(0, 8'h00, 8'hFF, 8'h00, 0, 8'h03);
        wait_idle();
        launch_xfer(0, 8'hFF, 8'h00, 8'h00, 0, 8'h03);
        csr_write(3'd4, 8'h77);
        wait_idle();
        csr_read(3'd4, v); check("R8", "data kept", v, 8'h00);
        csr_read(3'd2, v); check("R8", "lwb on data write", v, 8'h05);
        // read of all-ones
        launch_xfer(1, 8'h40, 8'h00, 8'hFF, 0, 8'h03);
        wait_idle();
        csr_read(3'd4, v); check("R4", "read all ones", v, 8'hFF);

        check("R2", "scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule